// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter

This block is a 16-bit up-counter with a small byte-wide register port. It can count the instruction-rate clock, which is the system clock divided by four. It can also count rising edges on an external clock pin. That pin is either passed through a two-flop synchronizer or used directly, which gives three modes: timer, synchronous counter and asynchronous counter.

A two-bit prescale field divides the selected source by 1, 2, 4 or 8 before it reaches the counter. A run bit gates counting. When enabled, a special event pulse from a compare unit clears the count. An overflow from 0xFFFF to 0x0000 sets a sticky flag.

Software reaches the count as two bytes. In buffered mode, the high byte goes through a holding register, so that a low-then-high read or a high-then-low write moves all 16 bits as one coherent value.

Top module: `evt_timer16`

## Requirements
- R1: After a synchronous reset the count, control register, overflow flag, high-byte buffer and read data are all zero.
- R2: With control bit 1 (source) at 0 and bit 0 (run) at 1, the count advances once every 4×N system clocks, where N is the prescale divisor. Any write to address 0 or 1 restarts the instruction-rate divider and the prescaler, so the first advance lands exactly 4×N clocks after that write.
- R3: Control bits 4:3 select the prescale divisor: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8.
- R4: With control bit 1 at 1, the count advances on rising edges of the external input. With control bit 2 at 1 (asynchronous), the count changes on the first clock edge after the input rises. With bit 2 at 0 (synchronized), it changes two edges later.
- R5: With control bit 0 at 0, the count holds its value whatever the sources do.
- R6: A special event pulse clears the count when control bit 6 is 1 and has no effect when it is 0. A clear beats a same-cycle increment. A count write beats a same-cycle clear.
- R7: An advance from 0xFFFF to 0x0000 sets the overflow flag output. The flag stays set until a write to address 3 loads it from data bit 0. Reading address 3 returns the flag in bit 0.
- R8: With control bit 5 at 0, address 0 and address 1 read and write the live low and high count bytes directly.
- R9: With control bit 5 at 1, a write to address 1 goes to the high-byte buffer only. A write to address 0 loads the count with the buffer above the written byte. A read of address 0 copies the live high byte into the buffer. A read of address 1 returns the buffer.
- R10: Read data is registered. It is valid the cycle after the read strobe and shows the addressed register as it stood before that edge. Address 2 returns the control register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk_i | input | 1 | External count input |
| sevt_i | input | 1 | Special event clear request from a compare unit |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 2 | Register address: 0 count low, 1 count high, 2 control, 3 status |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| ovf_flag_o | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that the bus issues at most one operation per cycle, so a read and a write never share an edge. They also assume the external input is low coming out of reset and that each high or low level lasts at least one clock, so that every rising edge is seen once. The stimulus keeps within these limits. It drives every input on the falling clock edge, performs one bus operation per task call, and shapes each external pulse as one full clock high followed by at least one clock low. The exact-cycle checks rely on the divider restart at count writes, which lets the bench compute advance times from the write edge alone.

// File: rtl/evt_tmr_pkg.sv
`timescale 1ns/1ps
package evt_tmr_pkg;

  typedef enum logic [1:0] {
    REG_CNT_LO = 2'd0,
    REG_CNT_HI = 2'd1,
    REG_CTRL   = 2'd2,
    REG_STAT   = 2'd3
  } reg_addr_e;

  // control register, packed from bit 6 down to bit 0
  typedef struct packed {
    logic       trig_clr;   // bit 6: special event clears count
    logic       buf16;      // bit 5: buffered high byte
    logic [1:0] psel;       // bits 4:3: prescale select
    logic       async_ext;  // bit 2: external edge bypasses synchronizer
    logic       src_ext;    // bit 1: count external edges
    logic       run;        // bit 0: counting enabled
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/evt_tmr_tick.sv
`timescale 1ns/1ps
module evt_tmr_tick #(
  parameter int unsigned PHASE_W     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_i,
  input  logic src_ext,
  input  logic async_ext,
  input  logic restart,
  output logic tick_o
);

  logic [PHASE_W-1:0]     phase_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_prev_q;
  logic                   raw_prev_q;
  logic                   sync_edge;
  logic                   raw_edge;
  logic                   int_tick;

  // instruction-rate divider
  always_ff @(posedge clk) begin
    if (rst || restart) phase_q <= '0;
    else                phase_q <= phase_q + 1'b1;
  end

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= ext_i;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], ext_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_prev_q <= 1'b0;
      raw_prev_q  <= 1'b0;
    end else begin
      sync_prev_q <= sync_q[SYNC_STAGES-1];
      raw_prev_q  <= ext_i;
    end
  end

  assign sync_edge = sync_q[SYNC_STAGES-1] & ~sync_prev_q;
  assign raw_edge  = ext_i & ~raw_prev_q;
  assign int_tick  = (phase_q == '1);

  always_comb begin
    if (!src_ext)       tick_o = int_tick;
    else if (async_ext) tick_o = raw_edge;
    else                tick_o = sync_edge;
  end

  // internal ticks are spaced by the divider, never back to back
  assert_int_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    (!src_ext && tick_o && !restart) |=> !tick_o);

  // a synchronized edge yields a single-cycle pulse
  assert_sync_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    (src_ext && !async_ext && sync_edge) |=> !sync_edge);

endmodule

// File: rtl/evt_tmr_prescale.sv
`timescale 1ns/1ps
module evt_tmr_prescale #(
  parameter int unsigned PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             tick_i,
  input  logic [PSC_W-1:0] psel,
  output logic             adv_o
);

  localparam int unsigned PCNT_W = (1 << PSC_W) - 1;

  logic [PCNT_W-1:0] pcnt_q;
  logic [PCNT_W-1:0] limit;
  logic              at_limit;

  always_comb limit = PCNT_W'((32'd1 << psel) - 32'd1);
  assign at_limit = (pcnt_q == limit);
  assign adv_o    = en & tick_i & at_limit;

  always_ff @(posedge clk) begin
    if (rst || clr)        pcnt_q <= '0;
    else if (en && tick_i) pcnt_q <= at_limit ? '0 : pcnt_q + 1'b1;
  end

  // after an advance the prescaler starts a fresh period
  assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (adv_o && !clr) |=> (pcnt_q == '0));

  // the count never runs past the selected limit
  assert_limit_R3: assert property (@(posedge clk) disable iff (rst)
    $stable(psel) |-> (pcnt_q <= limit));

endmodule

// File: rtl/evt_tmr_core.sv
`timescale 1ns/1ps
module evt_tmr_core #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic                rd_lo,
  input  logic                buf16,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                adv,
  input  logic                clr_evt,
  input  logic                flag_wr,
  input  logic                flag_wdata,
  output logic [2*DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0]   hbuf_o,
  output logic                flag_o
);

  localparam int unsigned CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] hbuf_q;
  logic              flag_q;
  logic              live_hi_wr;
  logic              cnt_write;
  logic              do_inc;

  assign live_hi_wr = wr_hi & ~buf16;
  assign cnt_write  = wr_lo | live_hi_wr;
  assign do_inc     = adv & ~cnt_write & ~clr_evt;

  always_ff @(posedge clk) begin
    if (rst)             cnt_q <= '0;
    else if (wr_lo)      cnt_q <= buf16 ? {hbuf_q, wdata} : {cnt_q[CNT_W-1:DATA_W], wdata};
    else if (live_hi_wr) cnt_q <= {wdata, cnt_q[DATA_W-1:0]};
    else if (clr_evt)    cnt_q <= '0;
    else if (adv)        cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                 hbuf_q <= '0;
    else if (buf16 && wr_hi) hbuf_q <= wdata;
    else if (buf16 && rd_lo) hbuf_q <= cnt_q[CNT_W-1:DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst)                           flag_q <= 1'b0;
    else if (flag_wr)                  flag_q <= flag_wdata;
    else if (do_inc && (cnt_q == '1))  flag_q <= 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign hbuf_o = hbuf_q;
  assign flag_o = flag_q;

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!adv && !cnt_write && !clr_evt) |=> $stable(cnt_q));

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!cnt_write && !clr_evt) |=>
      ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)));

  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_evt && !cnt_write) |=> (cnt_q == '0));

  assert_ovf_set_R7: assert property (@(posedge clk) disable iff (rst)
    (adv && (cnt_q == '1) && !cnt_write && !clr_evt && !flag_wr) |=> flag_o);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !flag_wr) |=> flag_o);

  assert_buf_write_R9: assert property (@(posedge clk) disable iff (rst)
    (buf16 && wr_hi) |=> $stable(cnt_q) || $past(adv) || $past(clr_evt));

endmodule

// File: rtl/evt_timer16.sv
`timescale 1ns/1ps
module evt_timer16
  import evt_tmr_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned PHASE_W     = 2,
  parameter int unsigned PSC_W       = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_clk_i,
  input  logic              sevt_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              ovf_flag_o
);

  localparam int unsigned CNT_W = 2 * DATA_W;

  ctrl_t             ctrl_q;
  reg_addr_e         addr;
  logic              wr_lo, wr_hi, wr_ctrl, wr_stat;
  logic              rd_lo;
  logic              restart;
  logic              clr_evt;
  logic              tick;
  logic              adv;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] hbuf;
  logic              flag;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;

  assign addr    = reg_addr_e'(bus_addr_i);
  assign wr_lo   = bus_wr_i && (addr == REG_CNT_LO);
  assign wr_hi   = bus_wr_i && (addr == REG_CNT_HI);
  assign wr_ctrl = bus_wr_i && (addr == REG_CTRL);
  assign wr_stat = bus_wr_i && (addr == REG_STAT);
  assign rd_lo   = bus_rd_i && (addr == REG_CNT_LO);
  assign restart = wr_lo | wr_hi;
  assign clr_evt = sevt_i & ctrl_q.trig_clr;

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata_i[CTRL_W-1:0]);
  end

  evt_tmr_tick #(
    .PHASE_W     (PHASE_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_tick (
    .clk       (clk),
    .rst       (rst),
    .ext_i     (ext_clk_i),
    .src_ext   (ctrl_q.src_ext),
    .async_ext (ctrl_q.async_ext),
    .restart   (restart),
    .tick_o    (tick)
  );

  evt_tmr_prescale #(
    .PSC_W (PSC_W)
  ) u_pscl (
    .clk    (clk),
    .rst    (rst),
    .clr    (restart),
    .en     (ctrl_q.run),
    .tick_i (tick),
    .psel   (ctrl_q.psel),
    .adv_o  (adv)
  );

  evt_tmr_core #(
    .DATA_W (DATA_W)
  ) u_core (
    .clk        (clk),
    .rst        (rst),
    .wr_lo      (wr_lo),
    .wr_hi      (wr_hi),
    .rd_lo      (rd_lo),
    .buf16      (ctrl_q.buf16),
    .wdata      (bus_wdata_i),
    .adv        (adv),
    .clr_evt    (clr_evt),
    .flag_wr    (wr_stat),
    .flag_wdata (bus_wdata_i[0]),
    .cnt_o      (cnt),
    .hbuf_o     (hbuf),
    .flag_o     (flag)
  );

  always_comb begin
    unique case (addr)
      REG_CNT_LO: rd_mux = cnt[DATA_W-1:0];
      REG_CNT_HI: rd_mux = ctrl_q.buf16 ? hbuf : cnt[CNT_W-1:DATA_W];
      REG_CTRL:   rd_mux = DATA_W'(ctrl_q);
      REG_STAT:   rd_mux = DATA_W'(flag);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rd_mux;
  end

  assign bus_rdata_o = rdata_q;
  assign ovf_flag_o  = flag;

  assert_one_op_R10: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr_i && bus_rd_i));

  assert_rd_status_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_i && (addr == REG_STAT)) |=> (bus_rdata_o == DATA_W'($past(ovf_flag_o))));

  assert_rdata_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_i |=> $stable(bus_rdata_o));

  assert_stopped_R5: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q.run |-> !adv);

endmodule

// File: tb/evt_timer16_test.sv
`timescale 1ns/1ps
module evt_timer16_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_clk = 1'b0;
  logic       sevt = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       ovf_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } exp_t;
  exp_t scb_q[$];

  always #2.5 clk = ~clk;

  evt_timer16 uut (
    .clk         (clk),
    .rst         (rst),
    .ext_clk_i   (ext_clk),
    .sevt_i      (sevt),
    .bus_wr_i    (bus_wr),
    .bus_rd_i    (bus_rd),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .ovf_flag_o  (ovf_flag)
  );

  // ---------------- monitor ----------------
  logic rd_d = 1'b0;
  always @(posedge clk) rd_d <= bus_rd;

  always @(negedge clk) begin
    if (rd_d) begin
      n_chk++;
      if (scb_q.size() == 0) begin
        n_fail++;
        $display("FAIL R10: read data %h with no expected item", bus_rdata);
      end else begin
        exp_t it;
        it = scb_q.pop_front();
        if (bus_rdata !== it.exp) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  // ---------------- driver ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic op_wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic op_wr_sevt(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; sevt = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; sevt = 1'b0;
  endtask

  task automatic op_rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    exp_t it;
    it.exp = e; it.tag = tag;
    scb_q.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_sevt();
    sevt = 1'b1;
    @(negedge clk);
    sevt = 1'b0;
  endtask

  task automatic pulse_ext();
    ext_clk = 1'b1;
    @(negedge clk);
    ext_clk = 1'b0;
  endtask

  task automatic check_flag(input logic e, input string tag);
    n_chk++;
    if (ovf_flag !== e) begin
      n_fail++;
      $display("FAIL %s: flag got %b expected %b", tag, ovf_flag, e);
    end
  endtask

  task automatic set_count(input logic [7:0] hi, input logic [7:0] lo);
    op_wr(2'd1, hi);
    op_wr(2'd0, lo);
  endtask

  function automatic logic [7:0] int_exp(input logic [7:0] base, input int m, input int div);
    return base + 8'((m) / (4 * div));
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check_flag(1'b0, "R1");
    op_rd(2'd2, 8'h00, "R1 ctrl");
    op_rd(2'd0, 8'h00, "R1 lo");
    op_rd(2'd1, 8'h00, "R1 hi");
    op_rd(2'd3, 8'h00, "R1 stat");

    // R8: plain byte access
    op_wr(2'd2, 8'h00);
    set_count(8'h5A, 8'hC3);
    op_rd(2'd0, 8'hC3, "R8 lo");
    op_rd(2'd1, 8'h5A, "R8 hi");

    // R5: stopped count holds, internal and external sources
    idle(40);
    op_rd(2'd0, 8'hC3, "R5 internal");
    op_wr(2'd2, 8'h06);
    op_rd(2'd2, 8'h06, "R10 ctrl");
    for (int i = 0; i < 3; i++) begin pulse_ext(); idle(1); end
    idle(3);
    op_rd(2'd0, 8'hC3, "R5 external");

    // R2 / R3: internal rate with each prescale setting
    for (int ps = 0; ps < 4; ps++) begin
      op_wr(2'd2, 8'(8'h01 | (ps << 3)));
      set_count(8'h00, 8'h10);
      idle(37);
      op_rd(2'd0, int_exp(8'h10, 37, 1 << ps), ps == 0 ? "R2 div1" : "R3 prescaled");
    end

    // R2: first advance exactly four clocks after the write
    op_wr(2'd2, 8'h01);
    set_count(8'h00, 8'h50);
    idle(3);
    op_rd(2'd0, 8'h50, "R2 before first advance");
    op_rd(2'd0, 8'h51, "R2 first advance");

    // R4: asynchronous external edge
    op_wr(2'd2, 8'h07);
    set_count(8'h00, 8'h20);
    pulse_ext();
    op_rd(2'd0, 8'h21, "R4 async");
    // R4: synchronized external edge, two edges later
    op_wr(2'd2, 8'h03);
    set_count(8'h00, 8'h40);
    pulse_ext();
    op_rd(2'd0, 8'h40, "R4 sync early");
    idle(2);
    op_rd(2'd0, 8'h41, "R4 sync late");

    // R3: prescaled external edges
    op_wr(2'd2, 8'h0F);
    set_count(8'h00, 8'h00);
    for (int i = 0; i < 5; i++) begin pulse_ext(); idle(1); end
    idle(4);
    op_rd(2'd0, 8'h02, "R3 ext div2");
    op_wr(2'd2, 8'h1F);
    set_count(8'h00, 8'h00);
    for (int i = 0; i < 7; i++) begin pulse_ext(); idle(1); end
    idle(4);
    op_rd(2'd0, 8'h00, "R3 ext div8 seven");
    pulse_ext(); idle(4);
    op_rd(2'd0, 8'h01, "R3 ext div8 eighth");

    // R6: special event clear
    op_wr(2'd2, 8'h41);
    set_count(8'h12, 8'h34);
    idle(1);
    pulse_sevt();
    op_rd(2'd0, 8'h00, "R6 clear lo");
    op_rd(2'd1, 8'h00, "R6 clear hi");
    set_count(8'h12, 8'h34);
    idle(3);
    pulse_sevt();
    op_rd(2'd0, 8'h00, "R6 clear beats increment");
    op_wr_sevt(2'd0, 8'h77);
    op_rd(2'd0, 8'h77, "R6 write beats clear");
    op_wr(2'd2, 8'h00);
    set_count(8'h12, 8'h34);
    pulse_sevt();
    op_rd(2'd0, 8'h34, "R6 trigger disabled");

    // R7: overflow flag
    op_wr(2'd2, 8'h01);
    set_count(8'hFF, 8'hFE);
    idle(7);
    check_flag(1'b0, "R7 before wrap");
    idle(1);
    check_flag(1'b1, "R7 at wrap");
    op_rd(2'd3, 8'h01, "R7 status");
    idle(10);
    check_flag(1'b1, "R7 sticky");
    op_wr(2'd3, 8'h00);
    check_flag(1'b0, "R7 cleared by write");

    // R9: buffered high byte
    op_wr(2'd2, 8'h20);
    set_count(8'hAB, 8'hCD);
    op_rd(2'd0, 8'hCD, "R9 lo");
    op_rd(2'd1, 8'hAB, "R9 hi");
    op_wr(2'd1, 8'h12);
    op_rd(2'd0, 8'hCD, "R9 lo after hi write");
    op_rd(2'd1, 8'hAB, "R9 live hi untouched");
    op_wr(2'd2, 8'h21);
    set_count(8'h00, 8'hFF);
    idle(3);
    op_rd(2'd0, 8'hFF, "R9 atomic lo");
    idle(10);
    op_rd(2'd1, 8'h00, "R9 atomic hi from buffer");
    op_wr(2'd2, 8'h01);
    op_rd(2'd1, 8'h01, "R8 live hi");

    idle(3);
    n_chk++;
    if (scb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R10: %0d reads pending, expected 0", scb_q.size());
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule